// File: doc/BRIEF.md
# Coherent Split-Counter Snapshot Reader

This block takes a tear-free snapshot of a 16-bit down-counter that keeps running while it is read and that can only be reached through an 8-bit port. The port has an internal byte-select flip-flop: a clear strobe points it at the low byte, and each read strobe returns one byte and then flips the selection to the other byte. Because the counter can move between two byte reads, one low/high pair may be torn by a carry out of the low byte.

The reader reads the counter twice. Each read is a clear followed by two byte reads, low then high. It compares the two low bytes to find the pair that no rollover split. The chosen raw value is one less than the number of units still to move, so the reader adds one and keeps 16 bits. The value that a counter shows after terminal count (all ones) therefore reports zero. When the channel moves 16-bit words, the reader doubles the count to give bytes. A single start strobe launches the whole sequence. A one-cycle done pulse marks the moment the result is valid.

Top module: `snap_reader`

## Requirements
- R1: In the cycle after an accepted start, the block drives exactly one port strobe per cycle for six cycles, in this order: clear, read, read, clear, read, read. Clear is `ff_clr_o` and read is `rd_o`. In every other cycle both strobes are low.
- R2: The block captures `rd_data_i` at the clock edge that ends each read cycle. The first read after each clear is taken as the low byte and the second as the high byte.
- R3: If the first low byte is greater than or equal to the second low byte, the result uses the first low/high pair. Otherwise it uses the second pair.
- R4: The count is the chosen 16-bit raw value (high byte times 256 plus low byte) plus one, kept to 16 bits. A raw value of 0xFFFF gives 0 and a raw value of 0x00FF gives 0x0100.
- R5: With `word_i` high when start is accepted, the 17-bit result is the R4 count times two. With `word_i` low, bit 16 of the result is 0. `word_i` is sampled only with an accepted start.
- R6: `done_o` is high for exactly one cycle, the cycle after the edge that captures the final high byte. `count_o` takes the new result in that same cycle and holds it until the next done pulse.
- R7: A start strobe is accepted only when no sequence is running, including the cycle in which `done_o` is high. A start that arrives while a sequence is running has no effect on the strobes or the result.
- R8: While reset is held, both strobes and `done_o` are low and `count_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one snapshot sequence |
| word_i | input | 1 | 1: channel moves 16-bit words, result doubled |
| rd_data_i | input | 8 | Byte returned by the counter port during a read cycle |
| ff_clr_o | output | 1 | Clears the port's byte-select flip-flop |
| rd_o | output | 1 | Read strobe to the counter port |
| done_o | output | 1 | One-cycle pulse: `count_o` is new |
| count_o | output | 17 | Units remaining, in bytes for word channels |

## Verification
If start is sampled at edge 0, the clear strobes are due in the cycles after edges 0 and 3. The reads are due after edges 1, 2, 4 and 5. The done pulse and the new count appear after edge 6. A behavioural reference model in the bench advances a phase counter on each rising edge, and also gathers the bytes that its own model of the counter port returned. It predicts all four outputs for the following cycle. The outputs are compared at every falling edge, so each expected value is read half a cycle after the edge that produces it. Directed cases use a frozen counter to get exact values, and a counter that steps every cycle across a low-byte wrap to exercise both pair choices.

// File: rtl/snap_pkg.sv
package snap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_CLR1 = 3'd1,
        ST_LO1  = 3'd2,
        ST_HI1  = 3'd3,
        ST_CLR2 = 3'd4,
        ST_LO2  = 3'd5,
        ST_HI2  = 3'd6
    } seq_state_e;

endpackage

// File: rtl/snap_select.sv
module snap_select #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0]   lo1_i,
    input  logic [BYTE_W-1:0]   hi1_i,
    input  logic [BYTE_W-1:0]   lo2_i,
    input  logic [BYTE_W-1:0]   hi2_i,
    input  logic                word_i,
    output logic [2*BYTE_W:0]   units_o
);
    localparam int CNT_W = 2 * BYTE_W;

    logic [CNT_W-1:0] pick;
    logic [CNT_W-1:0] plus_one;

    always_comb begin
        // A rollover between the reads makes the second low byte larger.
        if (lo1_i >= lo2_i) begin
            pick = {hi1_i, lo1_i};
        end else begin
            pick = {hi2_i, lo2_i};
        end
        plus_one = pick + {{(CNT_W-1){1'b0}}, 1'b1};
        if (word_i) begin
            units_o = {plus_one, 1'b0};
        end else begin
            units_o = {1'b0, plus_one};
        end
    end

endmodule

// File: rtl/snap_seq.sv
module snap_seq
    import snap_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                word_i,
    input  logic [BYTE_W-1:0]   rd_data_i,
    input  logic [2*BYTE_W:0]   units_i,
    output logic [BYTE_W-1:0]   lo1_o,
    output logic [BYTE_W-1:0]   hi1_o,
    output logic [BYTE_W-1:0]   lo2_o,
    output logic                word_o,
    output logic                ff_clr_o,
    output logic                rd_o,
    output logic                done_o,
    output logic [2*BYTE_W:0]   count_o
);
    localparam int CNT_W = 2 * BYTE_W;

    typedef struct packed {
        seq_state_e         st;
        logic [BYTE_W-1:0]  lo1;
        logic [BYTE_W-1:0]  hi1;
        logic [BYTE_W-1:0]  lo2;
        logic               word;
        logic               done;
        logic [CNT_W:0]     cnt;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st   = ST_CLR1;
                    r_d.word = word_i;
                end
            end
            ST_CLR1: r_d.st = ST_LO1;
            ST_LO1: begin
                r_d.lo1 = rd_data_i;
                r_d.st  = ST_HI1;
            end
            ST_HI1: begin
                r_d.hi1 = rd_data_i;
                r_d.st  = ST_CLR2;
            end
            ST_CLR2: r_d.st = ST_LO2;
            ST_LO2: begin
                r_d.lo2 = rd_data_i;
                r_d.st  = ST_HI2;
            end
            ST_HI2: begin
                r_d.cnt  = units_i;
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ff_clr_o = (r_q.st == ST_CLR1) || (r_q.st == ST_CLR2);
    assign rd_o     = (r_q.st == ST_LO1) || (r_q.st == ST_HI1) ||
                      (r_q.st == ST_LO2) || (r_q.st == ST_HI2);
    assign done_o   = r_q.done;
    assign count_o  = r_q.cnt;
    assign lo1_o    = r_q.lo1;
    assign hi1_o    = r_q.hi1;
    assign lo2_o    = r_q.lo2;
    assign word_o   = r_q.word;

    // R1: a clear is always followed by two reads
    a_r1_clr_then_read: assert property (@(posedge clk) disable iff (!rst_n)
        ff_clr_o |=> (rd_o && !ff_clr_o));
    a_r1_read_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_o && $past(ff_clr_o)) |=> (rd_o && !ff_clr_o));
    // R6: single-cycle done that closes a read, count steady otherwise
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r6_done_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(rd_o));
    a_r6_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(count_o));
    // R7: a start during a running sequence does not restart it
    a_r7_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && r_q.st != ST_IDLE) |=> (r_q.st != ST_CLR1));

endmodule

// File: rtl/snap_reader.sv
module snap_reader #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                word_i,
    input  logic [BYTE_W-1:0]   rd_data_i,
    output logic                ff_clr_o,
    output logic                rd_o,
    output logic                done_o,
    output logic [2*BYTE_W:0]   count_o
);
    logic [BYTE_W-1:0] lo1, hi1, lo2;
    logic              word_lat;
    logic [2*BYTE_W:0] units;

    snap_seq #(.BYTE_W(BYTE_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .word_i    (word_i),
        .rd_data_i (rd_data_i),
        .units_i   (units),
        .lo1_o     (lo1),
        .hi1_o     (hi1),
        .lo2_o     (lo2),
        .word_o    (word_lat),
        .ff_clr_o  (ff_clr_o),
        .rd_o      (rd_o),
        .done_o    (done_o),
        .count_o   (count_o)
    );

    // The final high byte is taken directly from the port in its read cycle.
    snap_select #(.BYTE_W(BYTE_W)) u_select (
        .lo1_i   (lo1),
        .hi1_i   (hi1),
        .lo2_i   (lo2),
        .hi2_i   (rd_data_i),
        .word_i  (word_lat),
        .units_o (units)
    );

endmodule

// File: tb/snap_reader_test.sv
module snap_reader_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        word_i = 1'b0;
    logic [7:0]  rd_data_i;
    logic        ff_clr_o, rd_o, done_o;
    logic [16:0] count_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    snap_reader uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .word_i    (word_i),
        .rd_data_i (rd_data_i),
        .ff_clr_o  (ff_clr_o),
        .rd_o      (rd_o),
        .done_o    (done_o),
        .count_o   (count_o)
    );

    // Model of the counter port: down-counter with a byte-select flip-flop.
    logic [15:0] ctr = 16'h0;
    logic        sel_hi = 1'b0;
    logic        ld_en = 1'b0;
    logic [15:0] ld_val = 16'h0;
    logic        step_en = 1'b0;

    assign rd_data_i = sel_hi ? ctr[15:8] : ctr[7:0];

    always @(posedge clk) begin
        if (ld_en) ctr <= ld_val;
        else if (step_en) ctr <= ctr - 16'd1;
        if (ff_clr_o) sel_hi <= 1'b0;
        else if (rd_o) sel_hi <= ~sel_hi;
    end

    // Behavioural reference: phase count plus the bytes seen on each read.
    int          ph = 0;
    bit          e_word = 0;
    bit          e_done = 0;
    int          e_cnt = 0;
    int          second_pair_hits = 0;
    logic [7:0]  b_lo1, b_hi1, b_lo2, b_hi2;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph = 0; e_done = 0; e_cnt = 0;
        end else begin
            e_done = 0;
            if (ph == 0) begin
                if (start_i) begin ph = 1; e_word = word_i; end
            end else if (ph == 6) begin
                int raw;
                b_hi2 = rd_data_i;
                if (b_lo1 >= b_lo2) raw = b_hi1 * 256 + b_lo1;
                else begin raw = b_hi2 * 256 + b_lo2; second_pair_hits++; end
                e_cnt = (raw + 1) % 65536;
                if (e_word) e_cnt = e_cnt * 2;
                e_done = 1;
                ph = 0;
            end else begin
                if (ph == 2) b_lo1 = rd_data_i;
                if (ph == 3) b_hi1 = rd_data_i;
                if (ph == 5) b_lo2 = rd_data_i;
                ph = ph + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference model.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit exp_clr, exp_rd;
            exp_clr = (ph == 1) || (ph == 4);
            exp_rd  = (ph == 2) || (ph == 3) || (ph == 5) || (ph == 6);
            check(ff_clr_o == exp_clr, "R1/R7 clear strobe", int'(ff_clr_o), int'(exp_clr));
            check(rd_o == exp_rd, "R1/R7 read strobe", int'(rd_o), int'(exp_rd));
            check(done_o == e_done, "R6 done pulse", int'(done_o), int'(e_done));
            check(int'(count_o) == e_cnt, "R2/R3/R4/R5/R6 count", int'(count_o), e_cnt);
        end
    end

    task automatic run_one(input logic [15:0] val, input bit word, input bit step);
        @(negedge clk);
        ld_en = 1'b1; ld_val = val; step_en = step;
        @(negedge clk);
        ld_en = 1'b0; start_i = 1'b1; word_i = word;
        @(negedge clk);
        start_i = 1'b0; word_i = 1'b0;
        repeat (7) @(negedge clk);
        step_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check(ff_clr_o == 1'b0, "R8 clear low in reset", int'(ff_clr_o), 0);
        check(rd_o == 1'b0, "R8 read low in reset", int'(rd_o), 0);
        check(done_o == 1'b0, "R8 done low in reset", int'(done_o), 0);
        check(count_o == 17'd0, "R8 count zero in reset", int'(count_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R4: post-terminal value reports zero
        run_one(16'hFFFF, 1'b0, 1'b0);
        check(count_o == 17'd0, "R4 all-ones gives zero", int'(count_o), 0);
        // R4: carry into high byte
        run_one(16'h00FF, 1'b0, 1'b0);
        check(count_o == 17'h00100, "R4 carry", int'(count_o), 'h100);
        // R5: word channel doubles
        run_one(16'h1234, 1'b1, 1'b0);
        check(count_o == 17'h0246A, "R5 word doubled", int'(count_o), 'h246A);
        run_one(16'hFFFE, 1'b1, 1'b0);
        check(count_o == 17'h1FFFE, "R5 17-bit result", int'(count_o), 'h1FFFE);
        run_one(16'hFFFE, 1'b0, 1'b0);
        check(count_o[16] == 1'b0, "R5 byte channel bit 16 clear", int'(count_o), 'hFFFF);

        // R2/R3: running counter across low-byte wraps, both pair choices
        for (int s = 0; s < 12; s++) begin
            run_one(16'h1206 - 16'(s), s[0], 1'b1);
        end
        for (int s = 0; s < 6; s++) begin
            run_one(16'h0003 - 16'(s), 1'b0, 1'b1);
        end
        check(second_pair_hits > 0, "R3 second pair chosen at least once",
              second_pair_hits, 1);

        // R7: start pulses while busy, and start in the done cycle
        @(negedge clk);
        ld_en = 1'b1; ld_val = 16'h4321; step_en = 1'b0;
        @(negedge clk);
        ld_en = 1'b0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        start_i = 1'b1;  word_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;  word_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        check(done_o == 1'b1, "R7 done on time despite busy starts", int'(done_o), 1);
        check(count_o == 17'h4322, "R7 busy start left word flag unused", int'(count_o), 'h4322);
        start_i = 1'b1;  ld_en = 1'b1; ld_val = 16'h0010;
        @(negedge clk);
        start_i = 1'b0;  ld_en = 1'b0;
        repeat (8) @(negedge clk);
        check(count_o == 17'h0011, "R7 start in done cycle accepted", int'(count_o), 'h11);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #50000;
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule